// File: doc/BRIEF.md
# Color Lookup Table Host Access Controller

This block sits between a host processor bus and a color lookup table of 256 RGB entries plus a bank of 15 overlay color entries. The host issues read and write strobes on an 8-bit bidirectional data bus. Each strobe carries a 3-bit select code that picks a target: an address register, table data, a read mask register or a command register. Both strobes are sampled by the block clock. The select code is taken when a strobe starts. Write data is taken from the last clock cycle in which the write strobe was high, and the access takes effect when the strobe ends.

Table entries are loaded as three byte writes in the order red, green, blue, from one shared address register. Only the blue write stores the joined word, and the address then advances by one. A whole table can therefore be loaded from a single start address. Reads use prefetch. Loading a read address copies the addressed entry into three holding registers and advances the address. Three data reads then return red, green and blue from those registers. After the blue read, the next entry is fetched and the address advances again.

A command register drives eight control outputs continuously. One of its bits selects 8-bit or 6-bit color components. The lookup memories are modelled inside the block as plain register arrays.

Top module: `vdac_mpu_ctrl`

## Requirements
- R1: After reset the control outputs are 0x00, which selects 6-bit components. The read mask register reads 0xFF and the address register reads 0x00.
- R2: The select codes are: 000 table write address, 001 table data, 010 read mask, 011 table read address, 100 overlay write address, 101 overlay data, 110 command, 111 overlay read address. A read of any address code returns the current address register.
- R3: Data writes are taken in the order red, green, blue. Only the blue write stores the word {red, green, blue} at the current address, and the address then increments by one.
- R4: Writing any of the four address codes resets the component sequence to red. A partial red/green sequence that is cut off this way stores nothing.
- R5: Writing a read address (011 or 111) copies that entry into the holding registers and sets the address to the loaded value plus one. Data reads return red, green and blue in turn. After the blue read, the entry at the current address is loaded into the holding registers and the address increments.
- R6: The address register wraps from 255 to 0 when it increments.
- R7: Bit 1 of the command register set to 1 selects 8-bit components; set to 0 it selects 6-bit components. In 6-bit mode, writes keep only the low 6 bits of each byte, and data reads return bits 7:6 as zero.
- R8: Overlay entries use indices 1 to 15. A store to index 0 or to an index above 15 is dropped, but the address still increments. A fetch from such an index yields zero components. Overlay accesses never touch the color table.
- R9: The command register value appears on the control outputs from the cycle after its write strobe ends. The read mask register reads back the last value written to it.
- R10: The block drives the data bus only while a read strobe is high and leaves it floating otherwise. A change of the select lines during a strobe is ignored, and write data is taken from the end of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, active high |
| rd_en | input | 1 | Host read strobe, active high |
| reg_sel | input | 3 | Register select code |
| data_io | inout | 8 | Bidirectional host data bus |
| ctrl_out | output | 8 | Command register contents |

## Verification
Consecutive red/green/blue triplets from one start address test whether the address advances once per entry or once per byte. Loading the address at 255 shows whether the address wraps or overflows. A red/green pair cut off by an address reload, and then a full triplet, shows whether the component counter is cleared and whether a partial word leaks into the table. Writing 0xFF components and reading back entries written earlier, in 6-bit and in 8-bit mode, separates masking on write from masking on read. Overlay indices 0, 1 and 32 check the valid-index rule against the shared address. A write whose select and data lines change halfway through shows which edge of the strobe is used for each.

// File: rtl/vdac_mpu_pkg.sv
package vdac_mpu_pkg;

  typedef enum logic [2:0] {
    SEL_PAL_WADDR = 3'b000,
    SEL_PAL_DATA  = 3'b001,
    SEL_RMASK     = 3'b010,
    SEL_PAL_RADDR = 3'b011,
    SEL_OVL_WADDR = 3'b100,
    SEL_OVL_DATA  = 3'b101,
    SEL_CMD       = 3'b110,
    SEL_OVL_RADDR = 3'b111
  } sel_e;

  typedef enum logic [1:0] {
    COMP_RED   = 2'd0,
    COMP_GREEN = 2'd1,
    COMP_BLUE  = 2'd2,
    COMP_NONE  = 2'd3
  } comp_e;

  localparam int CMD_WIDE_BIT = 1;

endpackage

// File: rtl/vdac_mpu_strobe.sv
module vdac_mpu_strobe #(
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              wr_done,
  output logic              rd_done,
  output logic              rd_active,
  output logic [SEL_W-1:0]  sel_q,
  output logic [DATA_W-1:0] wdata_q
);

  logic              wr_q, rd_q;
  logic              wr_start, rd_start;
  logic [SEL_W-1:0]  sel_d;
  logic [DATA_W-1:0] wdata_d;

  always_comb begin
    wr_start  = wr_en & ~wr_q;
    rd_start  = rd_en & ~rd_q;
    wr_done   = wr_q & ~wr_en;
    rd_done   = rd_q & ~rd_en;
    rd_active = rd_q;
    sel_d     = (wr_start | rd_start) ? sel_in : sel_q;
    wdata_d   = wr_en ? data_in : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      sel_q   <= '0;
      wdata_q <= '0;
    end else begin
      wr_q    <= wr_en;
      rd_q    <= rd_en;
      sel_q   <= sel_d;
      wdata_q <= wdata_d;
    end
  end

  // R10: the two strobes are never high together
  assert_no_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en));

  // R10: select stays as captured while a write strobe is held
  assert_sel_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q && wr_en) |=> $stable(sel_q));

endmodule

// File: rtl/vdac_color_store.sv
module vdac_color_store #(
  parameter int DEPTH  = 256,
  parameter int FIRST  = 0,
  parameter int ADDR_W = 8,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic              w_ok, r_ok;

  function automatic logic in_range(input logic [ADDR_W-1:0] a);
    return (int'(a) >= FIRST) && (int'(a) < DEPTH);
  endfunction

  always_comb begin
    w_ok  = in_range(waddr);
    r_ok  = in_range(raddr);
    rdata = r_ok ? mem[raddr[IDX_W-1:0]] : '0;
  end

  always_ff @(posedge clk) begin
    if (we && w_ok) begin
      mem[waddr[IDX_W-1:0]] <= wdata;
    end
  end

endmodule

// File: rtl/vdac_mpu_ctrl.sv
module vdac_mpu_ctrl
  import vdac_mpu_pkg::*;
#(
  parameter int COMP_W    = 8,
  parameter int NARROW_W  = 6,
  parameter int ADDR_W    = 8,
  parameter int PAL_DEPTH = 256,
  parameter int OVL_DEPTH = 16,
  parameter int OVL_FIRST = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        reg_sel,
  inout  wire  [COMP_W-1:0] data_io,
  output logic [COMP_W-1:0] ctrl_out
);

  localparam int WORD_W = 3 * COMP_W;
  localparam logic [COMP_W-1:0] NARROW_MASK =
    {{(COMP_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic              wr_done, rd_done, rd_active;
  logic [2:0]        sel_q;
  logic [COMP_W-1:0] wdata_q;
  sel_e              sel_t;

  vdac_mpu_strobe #(.SEL_W(3), .DATA_W(COMP_W)) u_strobe (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .sel_in   (reg_sel),
    .data_in  (data_io),
    .wr_done  (wr_done),
    .rd_done  (rd_done),
    .rd_active(rd_active),
    .sel_q    (sel_q),
    .wdata_q  (wdata_q)
  );

  assign sel_t = sel_e'(sel_q);

  logic [ADDR_W-1:0] addr_q, addr_d;
  comp_e             comp_q, comp_d;
  logic [COMP_W-1:0] red_q, red_d, grn_q, grn_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic [COMP_W-1:0] mask_q, mask_d, cmd_q, cmd_d;

  logic              wide;
  logic [COMP_W-1:0] cmask;
  logic              is_data, is_addr, is_raddr, blue_wr;
  logic              pal_we, ovl_we, load_hold;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] st_wdata, pal_rdata, ovl_rdata, fetched;
  logic [COMP_W-1:0] bus_out, comp_val;

  always_comb begin
    wide     = cmd_q[CMD_WIDE_BIT];
    cmask    = wide ? {COMP_W{1'b1}} : NARROW_MASK;
    is_data  = (sel_t == SEL_PAL_DATA) || (sel_t == SEL_OVL_DATA);
    is_raddr = (sel_t == SEL_PAL_RADDR) || (sel_t == SEL_OVL_RADDR);
    is_addr  = is_raddr || (sel_t == SEL_PAL_WADDR) || (sel_t == SEL_OVL_WADDR);
    blue_wr  = wr_done && is_data && (comp_q == COMP_BLUE);
    rd_addr  = (wr_done && is_raddr) ? wdata_q : addr_q;
    st_wdata = {red_q, grn_q, wdata_q & cmask};
    fetched  = sel_q[2] ? ovl_rdata : pal_rdata;
  end

  vdac_color_store #(
    .DEPTH(PAL_DEPTH), .FIRST(0), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_palette (
    .clk(clk), .we(pal_we), .waddr(addr_q), .wdata(st_wdata),
    .raddr(rd_addr), .rdata(pal_rdata)
  );

  vdac_color_store #(
    .DEPTH(OVL_DEPTH), .FIRST(OVL_FIRST), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
  ) u_overlay (
    .clk(clk), .we(ovl_we), .waddr(addr_q), .wdata(st_wdata),
    .raddr(rd_addr), .rdata(ovl_rdata)
  );

  // next-state logic
  always_comb begin
    addr_d    = addr_q;
    comp_d    = comp_q;
    red_d     = red_q;
    grn_d     = grn_q;
    hold_d    = hold_q;
    mask_d    = mask_q;
    cmd_d     = cmd_q;
    pal_we    = 1'b0;
    ovl_we    = 1'b0;
    load_hold = 1'b0;
    if (wr_done) begin
      unique case (sel_t)
        SEL_PAL_WADDR, SEL_OVL_WADDR: begin
          addr_d = wdata_q;
          comp_d = COMP_RED;
        end
        SEL_PAL_RADDR, SEL_OVL_RADDR: begin
          addr_d    = wdata_q + ADDR_W'(1);
          comp_d    = COMP_RED;
          load_hold = 1'b1;
        end
        SEL_PAL_DATA, SEL_OVL_DATA: begin
          unique case (comp_q)
            COMP_RED: begin
              red_d  = wdata_q & cmask;
              comp_d = COMP_GREEN;
            end
            COMP_GREEN: begin
              grn_d  = wdata_q & cmask;
              comp_d = COMP_BLUE;
            end
            default: begin
              pal_we = ~sel_q[2];
              ovl_we = sel_q[2];
              addr_d = addr_q + ADDR_W'(1);
              comp_d = COMP_RED;
            end
          endcase
        end
        SEL_RMASK: mask_d = wdata_q;
        SEL_CMD:   cmd_d  = wdata_q;
        default:   ;
      endcase
    end else if (rd_done && is_data) begin
      unique case (comp_q)
        COMP_RED:   comp_d = COMP_GREEN;
        COMP_GREEN: comp_d = COMP_BLUE;
        default: begin
          load_hold = 1'b1;
          addr_d    = addr_q + ADDR_W'(1);
          comp_d    = COMP_RED;
        end
      endcase
    end
    if (load_hold) begin
      hold_d = fetched;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      addr_q <= '0;
      comp_q <= COMP_RED;
      red_q  <= '0;
      grn_q  <= '0;
      hold_q <= '0;
      mask_q <= '1;
      cmd_q  <= '0;
    end else begin
      addr_q <= addr_d;
      comp_q <= comp_d;
      red_q  <= red_d;
      grn_q  <= grn_d;
      hold_q <= hold_d;
      mask_q <= mask_d;
      cmd_q  <= cmd_d;
    end
  end

  // readback
  always_comb begin
    unique case (comp_q)
      COMP_RED:   comp_val = hold_q[WORD_W-1 -: COMP_W];
      COMP_GREEN: comp_val = hold_q[2*COMP_W-1 -: COMP_W];
      default:    comp_val = hold_q[COMP_W-1:0];
    endcase
    unique case (sel_t)
      SEL_PAL_DATA, SEL_OVL_DATA: bus_out = comp_val & cmask;
      SEL_RMASK:                  bus_out = mask_q;
      SEL_CMD:                    bus_out = cmd_q;
      default:                    bus_out = addr_q;
    endcase
  end

  assign data_io  = rd_active ? bus_out : {COMP_W{1'bz}};
  assign ctrl_out = cmd_q;

  // R3: a blue write advances the address by exactly one
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    blue_wr |=> addr_q == $past(addr_q) + ADDR_W'(1));

  // R4: an address load restarts the component sequence at red
  assert_cnt_clear_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_done && is_addr) |=> comp_q == COMP_RED);

  // R3: the component counter never reaches the unused code
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    comp_q != COMP_NONE);

  // R7: in narrow mode, data reads keep the top bits at zero
  assert_narrow_read_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (rd_active && is_data && !wide) |-> data_io[COMP_W-1:NARROW_W] == '0);

  // R9: control outputs follow a command write on the next cycle
  assert_ctrl_follow_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_done && sel_t == SEL_CMD) |=> ctrl_out == $past(wdata_q));

endmodule

// File: tb/vdac_mpu_ctrl_bench.sv
`timescale 1ns/1ps
module vdac_mpu_ctrl_bench;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic [2:0] reg_sel;
  logic [7:0] dout;
  wire  [7:0] data_io;
  logic [7:0] ctrl_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  assign data_io = wr_en ? dout : 8'bz;

  vdac_mpu_ctrl u_vdac_mpu_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_sel(reg_sel), .data_io(data_io), .ctrl_out(ctrl_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; dout = d; wr_en = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; rd_en = 1'b1;
    @(negedge clk);
    @(negedge clk); v = data_io; rd_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_rgb(input logic [2:0] s, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wr(s, r); wr(s, g); wr(s, b);
  endtask

  task automatic rd_rgb(input string req, input logic [2:0] s, input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    logic [7:0] v;
    rd(s, v); check(req, v, r);
    rd(s, v); check(req, v, g);
    rd(s, v); check(req, v, b);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ctrl after reset", ctrl_out, 8'h00);
    rd(3'b010, v); check("R1 mask after reset", v, 8'hFF);
    rd(3'b000, v); check("R1 address after reset", v, 8'h00);
    check("R10 bus idle floats", data_io, 8'bz);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'b110, 8'h82); check("R9 ctrl follows command", ctrl_out, 8'h82);
    wr(3'b010, 8'h5A); rd(3'b010, v); check("R9 mask readback", v, 8'h5A);
    rd(3'b110, v); check("R2 command readback", v, 8'h82);
  endtask

  task automatic t_table_write_read();
    logic [7:0] v;
    wr(3'b000, 8'h10);
    wr_rgb(3'b001, 8'h11, 8'h22, 8'h33);
    wr_rgb(3'b001, 8'h44, 8'h55, 8'h66);
    rd(3'b000, v); check("R3 address after two triplets", v, 8'h12);
    wr(3'b011, 8'h10);
    rd(3'b011, v); check("R5 address after prefetch", v, 8'h11);
    rd_rgb("R5 first entry", 3'b001, 8'h11, 8'h22, 8'h33);
    rd_rgb("R5 second entry", 3'b001, 8'h44, 8'h55, 8'h66);
    rd(3'b000, v); check("R5 address after two reads", v, 8'h13);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wr(3'b000, 8'hFF);
    wr_rgb(3'b001, 8'hA1, 8'hA2, 8'hA3);
    rd(3'b000, v); check("R6 address wraps", v, 8'h00);
    wr_rgb(3'b001, 8'hB1, 8'hB2, 8'hB3);
    wr(3'b011, 8'hFF);
    rd(3'b000, v); check("R6 prefetch address wraps", v, 8'h00);
    rd_rgb("R6 entry 255", 3'b001, 8'hA1, 8'hA2, 8'hA3);
    rd_rgb("R6 entry 0", 3'b001, 8'hB1, 8'hB2, 8'hB3);
  endtask

  task automatic t_partial();
    wr(3'b000, 8'h20);
    wr_rgb(3'b001, 8'h01, 8'h02, 8'h03);
    wr(3'b000, 8'h20);
    wr(3'b001, 8'hEE); wr(3'b001, 8'hEF);
    wr(3'b011, 8'h20);
    rd_rgb("R4 partial sequence stores nothing", 3'b001, 8'h01, 8'h02, 8'h03);
    wr(3'b000, 8'h20);
    wr(3'b001, 8'hEE);
    wr(3'b000, 8'h20);
    wr_rgb(3'b001, 8'h07, 8'h08, 8'h09);
    wr(3'b011, 8'h20);
    rd_rgb("R4 counter restarts at red", 3'b001, 8'h07, 8'h08, 8'h09);
  endtask

  task automatic t_narrow();
    wr(3'b110, 8'h00); check("R7 narrow mode selected", ctrl_out, 8'h00);
    wr(3'b000, 8'h30);
    wr_rgb(3'b001, 8'hFF, 8'hC1, 8'h40);
    wr(3'b011, 8'h30);
    rd_rgb("R7 narrow write and read", 3'b001, 8'h3F, 8'h01, 8'h00);
    wr(3'b011, 8'h11);
    rd_rgb("R7 wide entry read narrow", 3'b001, 8'h04, 8'h15, 8'h26);
    wr(3'b110, 8'h02);
    wr(3'b011, 8'h30);
    rd_rgb("R7 narrow-stored entry read wide", 3'b001, 8'h3F, 8'h01, 8'h00);
  endtask

  task automatic t_overlay();
    logic [7:0] v;
    wr(3'b100, 8'h01);
    wr_rgb(3'b101, 8'hC0, 8'hC1, 8'hC2);
    wr(3'b100, 8'h00);
    wr_rgb(3'b101, 8'hD0, 8'hD1, 8'hD2);
    rd(3'b100, v); check("R8 address advances on dropped store", v, 8'h01);
    wr(3'b100, 8'h20);
    wr_rgb(3'b101, 8'hE0, 8'hE1, 8'hE2);
    wr(3'b111, 8'h01);
    rd(3'b111, v); check("R8 overlay prefetch address", v, 8'h02);
    rd_rgb("R8 overlay entry 1 intact", 3'b101, 8'hC0, 8'hC1, 8'hC2);
    wr(3'b111, 8'h00);
    rd_rgb("R8 overlay index 0 reads zero", 3'b101, 8'h00, 8'h00, 8'h00);
    wr(3'b111, 8'h20);
    rd_rgb("R8 overlay index 32 reads zero", 3'b101, 8'h00, 8'h00, 8'h00);
    wr(3'b011, 8'h00);
    rd_rgb("R8 table entry 0 untouched", 3'b001, 8'hB1, 8'hB2, 8'hB3);
    wr(3'b011, 8'h01);
    wr(3'b011, 8'h20);
    rd_rgb("R8 table entry 32 untouched", 3'b001, 8'h07, 8'h08, 8'h09);
  endtask

  task automatic t_capture();
    logic [7:0] v;
    @(negedge clk); reg_sel = 3'b110; dout = 8'h37; wr_en = 1'b1;
    @(negedge clk); reg_sel = 3'b010; dout = 8'h3E;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    check("R10 bus floats after write", data_io, 8'bz);
    @(negedge clk);
    check("R10 select from start data from end", ctrl_out, 8'h3E);
    rd(3'b010, v); check("R10 late select ignored", v, 8'h5A);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; reg_sel = 3'b000; dout = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_table_write_read();
    t_wrap();
    t_partial();
    t_narrow();
    t_overlay();
    t_capture();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule